// File: doc/BRIEF.md
# Relative Branch and Call Target Resolver

This block resolves where execution continues after a program-counter-relative control transfer. Each request gives the address of the transfer opcode, a signed displacement that is either 8 or 16 bits wide, a two-bit kind (conditional branch, unconditional branch or relative subroutine call) and, for the conditional kind, the already-evaluated condition. One clock edge later the block presents the next program counter, whether control moved away from the straight-line path, and, for a call, the return address that the stack logic should push.

The displacement is never an absolute address. It is added to the address of the first byte after the whole instruction. The short form is two bytes long (opcode and one displacement byte) and the long form is three bytes long (opcode and two displacement bytes). All address arithmetic wraps modulo 2^16. A call pushes the address of the last byte of its own instruction, one below the fall-through address.

The control is a four-state machine. ST_IDLE means no result this cycle. ST_FALL means a resolved but untaken conditional branch. ST_BRANCH means a taken branch, either conditional or unconditional. ST_CALL means a relative call. On every edge the machine goes to ST_IDLE when `req` is low. With `req` high it goes to ST_CALL for the call kind and to ST_BRANCH for the unconditional kind. For a conditional kind it goes to ST_BRANCH when `cond_met` is high and to ST_FALL when `cond_met` is low. Any state can reach any state on the next edge.

Top module: `branch_target_unit`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `out_valid`, `taken` and `push_ret` are 0, and `next_pc` and `ret_addr` are 0x0000.
- R2: Short form (`long_form`=0): the taken target is `op_addr` + 2 + the sign-extended `disp[7:0]`, with a reach of -128 to +127. `disp[15:8]` has no effect.
- R3: Long form (`long_form`=1): the taken target is `op_addr` + 3 + `disp[15:0]`, read as signed, with a reach of -32768 to +32767.
- R4: Kind 2'b00 is a conditional branch. When `cond_met` is 0, `taken` is 0 and `next_pc` is `op_addr` + 2 (short) or + 3 (long). When `cond_met` is 1, `taken` is 1 and `next_pc` is the target.
- R5: Kind 2'b01 is an unconditional branch. `taken` is 1 and `next_pc` is the target whatever `cond_met` is.
- R6: Kind 2'b10 is a relative call. `taken` and `push_ret` are 1 whatever `cond_met` is, `next_pc` is the target, and `ret_addr` is `op_addr` + 1 (short) or + 2 (long). `push_ret` is 0 for every other kind.
- R7: Kind 2'b11 behaves exactly like kind 2'b00.
- R8: Every sum wraps modulo 2^16, for the target, the fall-through address and the return address.
- R9: Results appear on the edge after a cycle with `req` high, with `out_valid` set. After a cycle with `req` low, `out_valid`, `taken` and `push_ret` are 0, and `next_pc` and `ret_addr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Resolve a transfer this cycle |
| kind | input | 2 | 00 conditional, 01 unconditional, 10 call, 11 conditional |
| long_form | input | 1 | 1: 16-bit displacement, 3-byte instruction |
| cond_met | input | 1 | Condition result for the conditional kind |
| op_addr | input | 16 | Address of the transfer opcode |
| disp | input | 16 | Signed displacement (low byte only in short form) |
| out_valid | output | 1 | A result is presented |
| taken | output | 1 | Control leaves the straight-line path |
| push_ret | output | 1 | A return address must be pushed |
| next_pc | output | 16 | Next program counter |
| ret_addr | output | 16 | Return address for a call |

## Verification
The assertions check on every cycle the timing and kind rules. A request always yields `out_valid` one edge later. An idle cycle clears the flags and holds both addresses. `push_ret` never appears without `taken`. The unconditional kind is always taken. An untaken conditional and a call produce the fall-through and return addresses from the previous cycle's `op_addr`. Only the bench scenarios show the taken-target arithmetic: sign extension of the short byte, the ignored upper byte, the largest forward and backward reach, and wrap-around at both ends of the address space.

// File: rtl/branch_target_pkg.sv
package branch_target_pkg;

    typedef enum logic [1:0] {
        KIND_COND     = 2'b00,
        KIND_ALWAYS   = 2'b01,
        KIND_CALL     = 2'b10,
        KIND_COND_ALT = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FALL   = 2'b01,
        ST_BRANCH = 2'b10,
        ST_CALL   = 2'b11
    } resolve_state_e;

endpackage

// File: rtl/disp_extend.sv
module disp_extend #(
    parameter int W       = 16,
    parameter int SHORT_W = 8
) (
    input  logic [W-1:0] disp_raw,
    input  logic         long_sel,
    output logic [W-1:0] disp_ext
);
    localparam int PAD = W - SHORT_W;

    logic [W-1:0] short_ext;

    // The short form uses only the low byte, sign-extended to full width
    assign short_ext = {{PAD{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
    assign disp_ext  = long_sel ? disp_raw : short_ext;
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    // The carry out is dropped, so the sum wraps modulo 2^W
    assign sum = a + b;
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
    import branch_target_pkg::*;
#(
    parameter int W       = 16,
    parameter int SHORT_W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [1:0]   kind,
    input  logic         long_form,
    input  logic         cond_met,
    input  logic [W-1:0] op_addr,
    input  logic [W-1:0] disp,
    output logic         out_valid,
    output logic         taken,
    output logic         push_ret,
    output logic [W-1:0] next_pc,
    output logic [W-1:0] ret_addr
);
    localparam logic [W-1:0] LEN_SHORT = W'(2);
    localparam logic [W-1:0] LEN_LONG  = W'(3);
    localparam logic [W-1:0] MINUS_ONE = '1;

    resolve_state_e state_q, state_d;
    xfer_kind_e     kind_e;
    logic [W-1:0]   ins_len, fall_addr, disp_full, target_addr, ret_calc;
    logic [W-1:0]   next_pc_q, ret_q;

    assign kind_e  = xfer_kind_e'(kind);
    assign ins_len = long_form ? LEN_LONG : LEN_SHORT;

    disp_extend #(.W(W), .SHORT_W(SHORT_W)) u_ext (
        .disp_raw (disp),
        .long_sel (long_form),
        .disp_ext (disp_full)
    );

    addr_adder #(.W(W)) u_fall (
        .a   (op_addr),
        .b   (ins_len),
        .sum (fall_addr)
    );

    addr_adder #(.W(W)) u_target (
        .a   (fall_addr),
        .b   (disp_full),
        .sum (target_addr)
    );

    // The return address is the last byte of the instruction
    addr_adder #(.W(W)) u_ret (
        .a   (fall_addr),
        .b   (MINUS_ONE),
        .sum (ret_calc)
    );

    // Next-state selection
    always_comb begin
        state_d = ST_IDLE;
        if (req) begin
            unique case (kind_e)
                KIND_CALL:   state_d = ST_CALL;
                KIND_ALWAYS: state_d = ST_BRANCH;
                default:     state_d = cond_met ? ST_BRANCH : ST_FALL;
            endcase
        end
    end

    // State and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            next_pc_q <= '0;
            ret_q     <= '0;
        end else begin
            state_q <= state_d;
            if (req) begin
                next_pc_q <= (state_d == ST_FALL) ? fall_addr : target_addr;
                ret_q     <= ret_calc;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        out_valid = 1'b1;
        taken     = 1'b0;
        push_ret  = 1'b0;
        unique case (state_q)
            ST_IDLE:   out_valid = 1'b0;
            ST_FALL:   taken     = 1'b0;
            ST_BRANCH: taken     = 1'b1;
            ST_CALL: begin
                taken    = 1'b1;
                push_ret = 1'b1;
            end
        endcase
    end

    assign next_pc  = next_pc_q;
    assign ret_addr = ret_q;
endmodule

// File: rtl/branch_target_chk.sv
module branch_target_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req,
    input logic [1:0]   kind,
    input logic         long_form,
    input logic         cond_met,
    input logic [W-1:0] op_addr,
    input logic [W-1:0] disp,
    input logic         out_valid,
    input logic         taken,
    input logic         push_ret,
    input logic [W-1:0] next_pc,
    input logic [W-1:0] ret_addr
);
    // R9
    req_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> out_valid);

    // R9
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!out_valid && !taken && !push_ret));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(next_pc) && $stable(ret_addr)));

    // R6
    push_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ret |-> (taken && out_valid));

    // R5
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && kind == 2'b01) |=> (taken && !push_ret));

    // R4
    fall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !kind[1] && kind[0] == 1'b0 && !cond_met) |=>
            (!taken && next_pc == ($past(op_addr) + ($past(long_form) ? W'(3) : W'(2)))));

    // R6
    call_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && kind == 2'b10) |=>
            (push_ret && ret_addr == ($past(op_addr) + ($past(long_form) ? W'(2) : W'(1)))));
endmodule

bind branch_target_unit branch_target_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .kind      (kind),
    .long_form (long_form),
    .cond_met  (cond_met),
    .op_addr   (op_addr),
    .disp      (disp),
    .out_valid (out_valid),
    .taken     (taken),
    .push_ret  (push_ret),
    .next_pc   (next_pc),
    .ret_addr  (ret_addr)
);

// File: tb/branch_target_unit_tb.sv
`timescale 1ns/1ps
module branch_target_unit_tb;

    typedef struct packed {
        logic [1:0]  kind;
        logic        lng;
        logic        cond;
        logic [15:0] op;
        logic [15:0] disp;
        logic [15:0] exp_pc;
        logic        exp_taken;
        logic [15:0] exp_ret;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b0, 1'b1, 16'h1000, 16'h0010, 16'h1012, 1'b1, 16'h1001}, // R2 fwd
        '{2'b00, 1'b0, 1'b1, 16'h1000, 16'h00F0, 16'h0FF2, 1'b1, 16'h1001}, // R2 back
        '{2'b00, 1'b0, 1'b1, 16'h2000, 16'hAB05, 16'h2007, 1'b1, 16'h2001}, // R2 upper ignored
        '{2'b00, 1'b0, 1'b0, 16'h1000, 16'h0040, 16'h1002, 1'b0, 16'h1001}, // R4 short
        '{2'b00, 1'b1, 1'b1, 16'h3000, 16'h1234, 16'h4237, 1'b1, 16'h3002}, // R3 fwd
        '{2'b00, 1'b1, 1'b1, 16'h3000, 16'hFF00, 16'h2F03, 1'b1, 16'h3002}, // R3 back
        '{2'b00, 1'b1, 1'b0, 16'h3000, 16'h1234, 16'h3003, 1'b0, 16'h3002}, // R4 long
        '{2'b01, 1'b0, 1'b0, 16'h4000, 16'h007F, 16'h4081, 1'b1, 16'h4001}, // R5
        '{2'b10, 1'b1, 1'b0, 16'h5000, 16'h0100, 16'h5103, 1'b1, 16'h5002}, // R6 long
        '{2'b10, 1'b0, 1'b1, 16'h5000, 16'h0080, 16'h4F82, 1'b1, 16'h5001}, // R6 short
        '{2'b00, 1'b1, 1'b1, 16'hFFF0, 16'h0020, 16'h0013, 1'b1, 16'hFFF2}, // R8 fwd
        '{2'b01, 1'b0, 1'b1, 16'h0000, 16'h00F0, 16'hFFF2, 1'b1, 16'h0001}, // R8 back
        '{2'b00, 1'b1, 1'b0, 16'hFFFE, 16'h0000, 16'h0001, 1'b0, 16'h0000}, // R8 fall
        '{2'b11, 1'b0, 1'b0, 16'h6000, 16'h0010, 16'h6002, 1'b0, 16'h6001}, // R7
        '{2'b00, 1'b1, 1'b1, 16'h0000, 16'h7FFF, 16'h8002, 1'b1, 16'h0002}  // R3 max
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic        long_form = 1'b0;
    logic        cond_met = 1'b0;
    logic [15:0] op_addr = '0;
    logic [15:0] disp = '0;
    logic        out_valid, taken, push_ret;
    logic [15:0] next_pc, ret_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    branch_target_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .kind      (kind),
        .long_form (long_form),
        .cond_met  (cond_met),
        .op_addr   (op_addr),
        .disp      (disp),
        .out_valid (out_valid),
        .taken     (taken),
        .push_ret  (push_ret),
        .next_pc   (next_pc),
        .ret_addr  (ret_addr)
    );

    task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req       = 1'b1;
        kind      = v.kind;
        long_form = v.lng;
        cond_met  = v.cond;
        op_addr   = v.op;
        disp      = v.disp;
    endtask

    task automatic check_vec(input string tag, input vec_t v);
        check({tag, " valid"}, 16'(out_valid), 16'h1);
        check({tag, " next_pc"}, next_pc, v.exp_pc);
        check({tag, " taken"}, 16'(taken), 16'(v.exp_taken));
        check({tag, " push_ret"}, 16'(push_ret), 16'(v.kind == 2'b10));
        check({tag, " ret_addr"}, ret_addr, v.exp_ret);
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t tmp;
        repeat (3) @(negedge clk);
        // R1: during reset
        check("R1 valid in reset", 16'(out_valid), 16'h0);
        check("R1 next_pc in reset", next_pc, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 taken after reset", 16'(taken), 16'h0);
        check("R1 push after reset", 16'(push_ret), 16'h0);
        check("R1 ret after reset", ret_addr, 16'h0000);

        // Table walk: R2 R3 R4 R5 R6 R7 R8, one result per edge (R9)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check_vec($sformatf("vec%0d", i), VEC[i]);
        end

        // R9: idle cycle clears flags, holds addresses of the last vector
        req = 1'b0;
        op_addr = 16'hAAAA;
        disp = 16'h5555;
        @(negedge clk);
        check("R9 idle valid", 16'(out_valid), 16'h0);
        check("R9 idle taken", 16'(taken), 16'h0);
        check("R9 idle push", 16'(push_ret), 16'h0);
        check("R9 idle hold pc", next_pc, 16'h8002);
        check("R9 idle hold ret", ret_addr, 16'h0002);

        // R5: unconditional kind with cond_met low and high both taken
        tmp = '{2'b01, 1'b1, 1'b0, 16'h7000, 16'h8000, 16'hF003, 1'b1, 16'h7002};
        drive(tmp);
        @(negedge clk);
        check_vec("R5 always long min", tmp);
        tmp.cond = 1'b1;
        drive(tmp);
        @(negedge clk);
        check_vec("R5 always cond high", tmp);

        // R7: kind 11 taken with cond_met high, no push
        tmp = '{2'b11, 1'b0, 1'b1, 16'h6000, 16'h0080, 16'h5F82, 1'b1, 16'h6001};
        drive(tmp);
        @(negedge clk);
        check_vec("R7 alt cond taken", tmp);

        // R1: reset mid-stream clears the result
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset valid", 16'(out_valid), 16'h0);
        check("R1 re-reset pc", next_pc, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule